// File: doc/BRIEF.md
# Receive Descriptor Ring Fill Engine

This block is the hardware side of a circular receive ring. Each ring slot holds a 4-bit status and one data word, which stands in for a received frame. The engine owns a current-slot pointer. Each arriving frame goes into the current slot, that slot is marked full, and the pointer moves on by one. Software recycles slots through a write port and observes them through a read port.

When the engine reaches a slot that is not empty, it raises a slot-error interrupt and stops filling. While it is stopped, new frames queue in a small local hold buffer. Filling that buffer raises a second interrupt. Frames that find the buffer full are dropped and counted. When filling resumes, the engine never retries the slot it refused; it carries on at the slot after it. Queued frames are stored before any new arrival.

Top module: `rx_ring_fill`

## Requirements
- R1: After reset every slot status reads 4'hF (not-in-use), `cur_ptr` is 0, `next_ptr` is 1, `halted` is 0, `irq_stat` is 0 and `drop_cnt` is 0.
- R2: A frame taken while running, with the slot at `cur_ptr` holding status 4'hA (empty), is written into that slot's data in the same clock edge. The slot status becomes 4'h4 (full) and `cur_ptr` advances by one.
- R3: `cur_ptr` wraps from RING_DEPTH-1 to 0. `next_ptr` always equals `cur_ptr`+1 modulo RING_DEPTH.
- R4: A frame taken while running, with the slot at `cur_ptr` not 4'hA, sets `irq_stat[0]` and sets `halted`. `cur_ptr` stays where it is and the frame is kept in the hold buffer.
- R5: While halted, arriving frames are queued in the hold buffer. The push that makes the buffer hold HOLD_DEPTH frames sets `irq_stat[1]`.
- R6: A frame that arrives while the hold buffer is full and nothing leaves it is dropped. `drop_cnt` then rises by one, saturating at its maximum, and `irq_stat[1]` is set.
- R7: Bits of `irq_stat` stay set until a cycle with the matching `irq_clr` bit at 1 clears them. A set event in the same cycle wins over the clear.
- R8: On leaving the halted state, `cur_ptr` moves to the slot after the refused one. This holds even if software has made the refused slot empty again.
- R9: The halted state is left by a `restart` pulse, or by a software write of 4'hA to the slot at `next_ptr`. A software write to any other slot leaves `halted` at 1. `restart` while running has no effect.
- R10: After resuming, frames in the hold buffer are stored before any new arrival, one per cycle, in arrival order.
- R11: `sw_wr_en` writes `sw_wr_status` into the slot at `sw_wr_idx` on the clock edge. `sw_rd_status` and `sw_rd_data` show the slot at `sw_rd_idx` without delay. If software and the engine write the same slot in the same cycle, the software write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One frame arrives this cycle |
| frm_data | input | DATA_W | Frame data word |
| restart | input | 1 | Leave the halted state |
| irq_clr | input | 2 | Write-one-to-clear for `irq_stat` |
| sw_wr_en | input | 1 | Software slot-status write strobe |
| sw_wr_idx | input | IDX_W | Slot written by software |
| sw_wr_status | input | 4 | Status value written |
| sw_rd_idx | input | IDX_W | Slot observed by software |
| sw_rd_status | output | 4 | Status of the observed slot |
| sw_rd_data | output | DATA_W | Data of the observed slot |
| cur_ptr | output | IDX_W | Slot the engine fills next |
| next_ptr | output | IDX_W | `cur_ptr`+1 modulo ring size |
| halted | output | 1 | Engine stopped on a non-empty slot |
| irq_stat | output | 2 | Bit 0 slot error, bit 1 hold buffer full |
| drop_cnt | output | CNT_W | Saturating count of dropped frames |

## Verification
The bench builds the engine with RING_DEPTH=8, HOLD_DEPTH=2, DATA_W=12 and CNT_W=4. With eight slots, a full sweep of every slot and the wrap back to slot 0 take only a few frames. A second pass then finds every slot full, so refusals, skips and repeated halts come up on consecutive slots. A two-entry hold buffer fills after two frames, so the buffer-full interrupt, drops, drain order and both resume paths are all reached within a short, hand-computable sequence.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam logic [3:0] ST_EMPTY = 4'hA;
  localparam logic [3:0] ST_FULL  = 4'h4;
  localparam logic [3:0] ST_IDLE  = 4'hF;

  typedef enum logic {
    ENG_RUN  = 1'b0,
    ENG_HALT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
  import rxr_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_data,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [3:0]        sw_status,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [3:0]        a_status,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [3:0]        b_status,
  output logic [DATA_W-1:0] b_data
);
  logic [3:0]        st_q  [ENTRIES];
  logic [DATA_W-1:0] dat_q [ENTRIES];

  // status: reset to not-in-use; software write is applied last so it wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= ST_IDLE;
    end else begin
      if (eng_we) st_q[eng_idx] <= ST_FULL;
      if (sw_we)  st_q[sw_idx]  <= sw_status;
    end
  end

  // frame data: storage only, no reset
  always_ff @(posedge clk) begin
    if (eng_we) dat_q[eng_idx] <= eng_data;
  end

  assign a_status = st_q[a_idx];
  assign b_status = st_q[b_idx];
  assign b_data   = dat_q[b_idx];
endmodule

// File: rtl/rxr_hold_fifo.sv
module rxr_hold_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
  import rxr_pkg::*;
#(
  parameter int RING_DEPTH = 256,
  parameter int HOLD_DEPTH = 4,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int HC_W      = $clog2(HOLD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              restart,
  input  logic [1:0]        irq_clr,
  input  logic              sw_wr_en,
  input  logic [IDX_W-1:0]  sw_wr_idx,
  input  logic [3:0]        sw_wr_status,
  input  logic [3:0]        cur_status,
  input  logic [HC_W-1:0]   hold_count,
  input  logic [DATA_W-1:0] hold_head,
  output logic              eng_we,
  output logic [DATA_W-1:0] eng_data,
  output logic              hold_push,
  output logic              hold_pop,
  output logic [IDX_W-1:0]  cur_ptr,
  output logic [IDX_W-1:0]  next_ptr,
  output logic              halted,
  output logic [1:0]        irq_stat,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);
  localparam logic [HC_W-1:0]  HOLD_MAX = HC_W'(HOLD_DEPTH);
  localparam logic [CNT_W-1:0] DROP_MAX = '1;

  eng_state_e       st_q, st_n;
  logic [IDX_W-1:0] cur_q, cur_n, nxt;
  logic [1:0]       irq_q, irq_n;
  logic [CNT_W-1:0] drop_q, drop_n;

  logic have_q, hold_full, running, cand, slot_ok, store, reject;
  logic push_req, drop, resume, fills;

  always_comb begin
    nxt       = (cur_q == LAST_IDX) ? '0 : cur_q + 1'b1;
    have_q    = (hold_count != '0);
    hold_full = (hold_count == HOLD_MAX);
    running   = (st_q == ENG_RUN);
    // queued frames go first; a direct arrival is taken only on an empty queue
    cand      = running && (have_q || frm_valid);
    eng_data  = have_q ? hold_head : frm_data;
    slot_ok   = (cur_status == ST_EMPTY);
    store     = cand && slot_ok;
    reject    = cand && !slot_ok;
    hold_pop  = store && have_q;
    push_req  = frm_valid && !(store && !have_q);
    hold_push = push_req && (!hold_full || hold_pop);
    drop      = push_req && !hold_push;
    fills     = hold_push && !hold_pop && (hold_count == HOLD_MAX - 1'b1);
    resume    = !running && (restart ||
                 (sw_wr_en && sw_wr_idx == nxt && sw_wr_status == ST_EMPTY));
    eng_we    = store;
  end

  always_comb begin
    st_n   = st_q;
    cur_n  = cur_q;
    drop_n = drop_q;
    if (store || resume) cur_n = nxt;
    if (reject)      st_n = ENG_HALT;
    else if (resume) st_n = ENG_RUN;
    if (drop && drop_q != DROP_MAX) drop_n = drop_q + 1'b1;
    irq_n = (irq_q & ~irq_clr) | {drop || fills, reject};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_RUN;
      cur_q  <= '0;
      irq_q  <= '0;
      drop_q <= '0;
    end else begin
      st_q   <= st_n;
      cur_q  <= cur_n;
      irq_q  <= irq_n;
      drop_q <= drop_n;
    end
  end

  assign cur_ptr  = cur_q;
  assign next_ptr = nxt;
  assign halted   = (st_q == ENG_HALT);
  assign irq_stat = irq_q;
  assign drop_cnt = drop_q;
endmodule

// File: rtl/rx_ring_fill.sv
module rx_ring_fill #(
  parameter int RING_DEPTH = 256,
  parameter int HOLD_DEPTH = 4,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int HC_W      = $clog2(HOLD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              restart,
  input  logic [1:0]        irq_clr,
  input  logic              sw_wr_en,
  input  logic [IDX_W-1:0]  sw_wr_idx,
  input  logic [3:0]        sw_wr_status,
  input  logic [IDX_W-1:0]  sw_rd_idx,
  output logic [3:0]        sw_rd_status,
  output logic [DATA_W-1:0] sw_rd_data,
  output logic [IDX_W-1:0]  cur_ptr,
  output logic [IDX_W-1:0]  next_ptr,
  output logic              halted,
  output logic [1:0]        irq_stat,
  output logic [CNT_W-1:0]  drop_cnt
);
  logic              eng_we, hold_push, hold_pop;
  logic [DATA_W-1:0] eng_data, hold_head;
  logic [HC_W-1:0]   hold_count;
  logic [3:0]        cur_status;

  rxr_fill_ctrl #(
    .RING_DEPTH(RING_DEPTH), .HOLD_DEPTH(HOLD_DEPTH),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_data(frm_data),
    .restart(restart), .irq_clr(irq_clr),
    .sw_wr_en(sw_wr_en), .sw_wr_idx(sw_wr_idx), .sw_wr_status(sw_wr_status),
    .cur_status(cur_status), .hold_count(hold_count), .hold_head(hold_head),
    .eng_we(eng_we), .eng_data(eng_data),
    .hold_push(hold_push), .hold_pop(hold_pop),
    .cur_ptr(cur_ptr), .next_ptr(next_ptr), .halted(halted),
    .irq_stat(irq_stat), .drop_cnt(drop_cnt)
  );

  rxr_hold_fifo #(.DEPTH(HOLD_DEPTH), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .push(hold_push), .push_data(frm_data), .pop(hold_pop),
    .head(hold_head), .count(hold_count)
  );

  rxr_desc_mem #(.ENTRIES(RING_DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .eng_we(eng_we), .eng_idx(cur_ptr), .eng_data(eng_data),
    .sw_we(sw_wr_en), .sw_idx(sw_wr_idx), .sw_status(sw_wr_status),
    .a_idx(cur_ptr), .a_status(cur_status),
    .b_idx(sw_rd_idx), .b_status(sw_rd_status), .b_data(sw_rd_data)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int RING_DEPTH = 256,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(RING_DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halted,
  input logic [IDX_W-1:0] cur_ptr,
  input logic [1:0]       irq_stat,
  input logic [1:0]       irq_clr,
  input logic [CNT_W-1:0] drop_cnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  p_halt_raises_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> irq_stat[0]);

  p_halt_holds_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(cur_ptr));

  p_resume_skips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> cur_ptr == (($past(cur_ptr) == LAST_IDX) ? '0
                                   : IDX_W'($past(cur_ptr) + 1'b1)));

  p_drop_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt != '0 |=> drop_cnt >= $past(drop_cnt));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]);

  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[1] && !irq_clr[1]) |=> irq_stat[1]);
endmodule

bind rx_ring_fill rxr_checker #(.RING_DEPTH(RING_DEPTH), .CNT_W(CNT_W)) u_rxr_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .cur_ptr(cur_ptr),
  .irq_stat(irq_stat), .irq_clr(irq_clr), .drop_cnt(drop_cnt)
);

// File: tb/test_rx_ring_fill.sv
`timescale 1ns/1ps
module test_rx_ring_fill;
  localparam int RD = 8;
  localparam int HD = 2;
  localparam int DW = 12;
  localparam int CW = 4;
  localparam int IW = $clog2(RD);

  logic clk = 1'b0;
  logic rst_n;
  logic frm_valid, restart, sw_wr_en;
  logic [DW-1:0] frm_data;
  logic [1:0] irq_clr;
  logic [IW-1:0] sw_wr_idx, sw_rd_idx;
  logic [3:0] sw_wr_status, sw_rd_status;
  logic [DW-1:0] sw_rd_data;
  logic [IW-1:0] cur_ptr, next_ptr;
  logic halted;
  logic [1:0] irq_stat;
  logic [CW-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_ring_fill #(.RING_DEPTH(RD), .HOLD_DEPTH(HD), .DATA_W(DW), .CNT_W(CW)) i_rx_ring_fill (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .restart(restart), .irq_clr(irq_clr), .sw_wr_en(sw_wr_en),
    .sw_wr_idx(sw_wr_idx), .sw_wr_status(sw_wr_status), .sw_rd_idx(sw_rd_idx),
    .sw_rd_status(sw_rd_status), .sw_rd_data(sw_rd_data), .cur_ptr(cur_ptr),
    .next_ptr(next_ptr), .halted(halted), .irq_stat(irq_stat), .drop_cnt(drop_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d);
    frm_valid = 1'b1; frm_data = d;
    tick();
    frm_valid = 1'b0;
  endtask

  task automatic swr(input int idx, input logic [3:0] st);
    sw_wr_en = 1'b1; sw_wr_idx = IW'(idx); sw_wr_status = st;
    tick();
    sw_wr_en = 1'b0;
  endtask

  task automatic look(input int idx, input string req, input logic [3:0] est,
                      input logic [DW-1:0] edat, input bit cmp_dat);
    sw_rd_idx = IW'(idx);
    #1;
    check(req, 32'(sw_rd_status), 32'(est));
    if (cmp_dat) check(req, 32'(sw_rd_data), 32'(edat));
  endtask

  task automatic ptrs(input string req, input int c, input bit h);
    check(req, 32'(cur_ptr), 32'(c));
    check(req, 32'(next_ptr), 32'((c + 1) % RD));
    check(req, 32'(halted), 32'(h));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_data = '0; restart = 1'b0;
    irq_clr = '0; sw_wr_en = 1'b0; sw_wr_idx = '0; sw_wr_status = '0; sw_rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < RD; i++) look(i, "R1 slot status", 4'hF, '0, 1'b0);
    ptrs("R1 pointers", 0, 1'b0);
    check("R1 irq", 32'(irq_stat), 0);
    check("R1 drops", 32'(drop_cnt), 0);

    // R11: software marks every slot empty
    for (int i = 0; i < RD; i++) swr(i, 4'hA);
    for (int i = 0; i < RD; i++) look(i, "R11 sw write", 4'hA, '0, 1'b0);

    // R2/R3: sweep every slot, wrap to 0
    for (int i = 0; i < RD; i++) begin
      send(DW'(12'h100 + i));
      ptrs("R3 advance/wrap", (i + 1) % RD, 1'b0);
    end
    for (int i = 0; i < RD; i++) look(i, "R2 stored", 4'h4, DW'(12'h100 + i), 1'b1);
    check("R2 no irq", 32'(irq_stat), 0);

    // R9: restart while running has no effect
    restart = 1'b1; tick(); restart = 1'b0;
    ptrs("R9 restart ignored when running", 0, 1'b0);

    // R4: slot 0 is full -> refuse
    send(12'h0D1);
    ptrs("R4 halt on full slot", 0, 1'b1);
    check("R4 err irq", 32'(irq_stat), 32'h1);
    tick();
    check("R7 sticky", 32'(irq_stat), 32'h1);

    // R5: second queued frame fills the buffer
    send(12'h0E2);
    check("R5 buffer full irq", 32'(irq_stat), 32'h3);
    check("R5 no drop yet", 32'(drop_cnt), 0);

    // R6: overflow drops
    send(12'h0F3);
    check("R6 drop 1", 32'(drop_cnt), 1);
    send(12'h0F4);
    check("R6 drop 2", 32'(drop_cnt), 2);

    // R7: write-one-to-clear, one bit at a time
    irq_clr = 2'b01; tick(); irq_clr = 2'b00;
    check("R7 clear bit0", 32'(irq_stat), 32'h2);
    irq_clr = 2'b10; tick(); irq_clr = 2'b00;
    check("R7 clear bit1", 32'(irq_stat), 0);
    ptrs("R7 still halted", 0, 1'b1);

    // R9: write to a slot other than next_ptr does not resume
    swr(0, 4'hA);
    ptrs("R9 other slot keeps halt", 0, 1'b1);

    // R8/R9: empty write to next_ptr resumes at slot 1
    swr(1, 4'hA);
    ptrs("R8 resume skips refused slot", 1, 1'b0);
    tick();
    ptrs("R10 first queued stored", 2, 1'b0);
    tick();
    ptrs("R4 second refusal", 2, 1'b1);
    check("R4 err irq again", 32'(irq_stat), 32'h1);
    look(0, "R8 refused slot untouched", 4'hA, '0, 1'b0);
    look(1, "R10 order first", 4'h4, 12'h0D1, 1'b1);

    // recycle 4..7, then resume by writing slot 3
    for (int i = 4; i < RD; i++) swr(i, 4'hA);
    ptrs("R9 writes elsewhere keep halt", 2, 1'b1);
    swr(3, 4'hA);
    ptrs("R8 resume at 3", 3, 1'b0);
    tick();
    ptrs("R10 drained", 4, 1'b0);
    look(3, "R10 order second", 4'h4, 12'h0E2, 1'b1);
    look(2, "R8 slot 2 kept", 4'h4, 12'h102, 1'b1);

    // fill 4..7 and slot 0 (emptied earlier), then refuse at slot 1
    for (int i = 0; i < 5; i++) send(DW'(12'h200 + i));
    ptrs("R3 wrap again", 1, 1'b0);
    look(0, "R2 refilled slot 0", 4'h4, 12'h204, 1'b1);
    look(7, "R2 slot 7", 4'h4, 12'h203, 1'b1);
    send(12'h205);
    ptrs("R4 refuse slot 1", 1, 1'b1);

    // R9: restart pulse resumes at 2, which is full -> refuse again
    restart = 1'b1; tick(); restart = 1'b0;
    ptrs("R9 restart resumes", 2, 1'b0);
    tick();
    ptrs("R4 refuse slot 2", 2, 1'b1);
    swr(3, 4'hA);
    tick();
    ptrs("R10 queued frame after resume", 4, 1'b0);
    look(3, "R10 stored after restart", 4'h4, 12'h205, 1'b1);
    check("R6 drops unchanged", 32'(drop_cnt), 2);

    finish_run();
  end
endmodule